// File: doc/BRIEF.md
# I2C Byte-Memory Target with Strap Address and Write Lock

This block is a two-wire bus target that sits in front of a byte-wide storage array. It watches the sampled clock and data lines from the bus, finds start and stop conditions, and reads in a device-select byte. The block answers only when the top nibble of that byte is the fixed code 4'b1010 and the next three bits equal its three strap inputs. A shared bus can therefore carry up to eight copies of the block, each with its own strap setting. An integrator ties any strap pin that is not used to 0.

After a write-mode select, the master sends two word-address bytes, high byte first. These load a 13-bit address counter. Each data byte that follows is stored at the counter, and the counter then moves on by one. After a read-mode select, the block sends out the byte at the counter, most significant bit first. It keeps sending bytes for as long as the master acknowledges. A level-sensitive lock input stops every store but has no effect on reads. The data line is driven open-drain: the output enable only ever pulls the line low.

The counter always spans 13 bits, which covers 8,192 byte locations. The behavioural array holds 2**MEM_AW bytes and is indexed by the low MEM_AW bits of the counter. Setting MEM_AW to 13 gives the full 8,192 × 8 array. The default of 11 keeps elaboration small.

Top module: `i2cmem_target`

## Requirements
- R1: The block acknowledges the select byte only when bits 7:4 equal 4'b1010 and bits 3:1 equal strap_i. On any other select byte it does not acknowledge and ignores the bus until the next start condition.
- R2: After a write select (bit 0 = 0), the block acknowledges a high address byte and then a low address byte. Only the low 5 bits of the high byte are used; its upper 3 bits are ignored.
- R3: The 13-bit address counter goes up by one after every data byte, whether stored or sent. It wraps from 0x1FFF to 0x0000.
- R4: While wp_lock_i is 1, data bytes in a write are still acknowledged, but no location changes.
- R5: Reads return the stored bytes no matter what level wp_lock_i has.
- R6: After a read select (bit 0 = 1), the block sends the byte at the counter, MSB first. It sends the next byte after each master acknowledge. After a master not-acknowledge it releases the data line.
- R7: A read select with no address phase in front of it starts at the counter value left by the previous transfer. A repeated start after the address phase gives a random read.
- R8: The data line is only ever pulled low or released, and the enable changes only while the clock line is low. Incoming data is taken on the rising clock edge.
- R9: A stop condition returns the block to idle with the data line released. Bytes sent after a stop without a new start are not acknowledged.
- R10: Counter value c selects array location c mod 2**MEM_AW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device address straps |
| wp_lock_i | input | 1 | 1 blocks all stores |

## Verification
Two things happen on the same system-clock edge: the store of a data byte and the counter step from 0x1FFF to 0x0000. The bench forces this by writing two bytes that start at address 0x1FFF. It judges the result by reading both bytes back and by reading the aliased location 0x07FF. A second overlap is a lock change close to the store decision. Random transfers flip wp_lock_i between transfers, and every read-back is compared with a bench model that skips locked stores.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WR,
      ST_RD
   } tgt_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cmem_busedge.sv
module i2cmem_busedge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_d, sda_d;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scl_s <= 1'b1;
            sda_s <= 1'b1;
         end else begin
            scl_s <= scl_i;
            sda_s <= sda_i;
         end
      end
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] scl_c, sda_c;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scl_c <= '1;
            sda_c <= '1;
         end else begin
            scl_c <= {scl_c[SYNC_STAGES-2:0], scl_i};
            sda_c <= {sda_c[SYNC_STAGES-2:0], sda_i};
         end
      end
      assign scl_s = scl_c[SYNC_STAGES-1];
      assign sda_s = sda_c[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

   AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scl_rise, scl_fall, start_ev, stop_ev})); // R8
endmodule

// File: rtl/i2cmem_array.sv
module i2cmem_array #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
   import i2cmem_pkg::*;
#(
   parameter int         ADDR_W      = 13,
   parameter int         MEM_AW      = 11,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wp_lock_i
);
   localparam int HI_W = ADDR_W - BYTE_W;
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [3:0] LAST_BIT = 4'd8;

   if (ADDR_W <= BYTE_W || ADDR_W > 2 * BYTE_W) begin : g_bad_aw
      $error("ADDR_W must lie in 9..16");
   end
   if (MEM_AW < 1 || MEM_AW > ADDR_W) begin : g_bad_mem
      $error("MEM_AW must lie in 1..ADDR_W");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   i2cmem_busedge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   tgt_state_e        state_q;
   logic [3:0]        bitcnt_q;
   logic [7:0]        shreg_q;
   logic [ADDR_W-1:0] addr_q;
   logic              sda_oe_q, ack_q, rnw_q, more_q;
   logic              mem_we, dev_match, rx_state;
   logic [7:0]        mem_rdata;

   assign dev_match = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_i);
   assign rx_state  = (state_q != ST_IDLE) && (state_q != ST_RD);
   assign mem_we    = (state_q == ST_WR) && scl_fall && !ack_q &&
                      (bitcnt_q == LAST_BIT) && !wp_lock_i;

   i2cmem_array #(.AW(MEM_AW)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .addr  (addr_q[MEM_AW-1:0]),
      .wdata (shreg_q),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         addr_q   <= '0;
         sda_oe_q <= 1'b0;
         ack_q    <= 1'b0;
         rnw_q    <= 1'b0;
         more_q   <= 1'b0;
      end else if (stop_ev) begin
         state_q  <= ST_IDLE;
         sda_oe_q <= 1'b0;
         ack_q    <= 1'b0;
      end else if (start_ev) begin
         state_q  <= ST_DEV;
         bitcnt_q <= '0;
         sda_oe_q <= 1'b0;
         ack_q    <= 1'b0;
      end else if (state_q == ST_RD) begin
         if (scl_fall) begin
            if (bitcnt_q < 4'd7) begin
               shreg_q  <= {shreg_q[6:0], 1'b0};
               sda_oe_q <= ~shreg_q[6];
               bitcnt_q <= bitcnt_q + 4'd1;
            end else if (bitcnt_q == 4'd7) begin
               sda_oe_q <= 1'b0;
               bitcnt_q <= LAST_BIT;
            end else if (bitcnt_q == 4'd9) begin
               if (more_q) begin
                  shreg_q  <= mem_rdata;
                  sda_oe_q <= ~mem_rdata[7];
                  addr_q   <= addr_q + ONE;
                  bitcnt_q <= '0;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
         end else if (scl_rise && bitcnt_q == LAST_BIT) begin
            more_q   <= ~sda_s;
            bitcnt_q <= 4'd9;
         end
      end else if (rx_state) begin
         if (scl_rise && !ack_q && bitcnt_q < LAST_BIT) begin
            shreg_q  <= {shreg_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 4'd1;
         end else if (scl_fall && ack_q) begin
            ack_q    <= 1'b0;
            sda_oe_q <= 1'b0;
            bitcnt_q <= '0;
            unique case (state_q)
               ST_DEV: begin
                  if (rnw_q) begin
                     state_q  <= ST_RD;
                     shreg_q  <= mem_rdata;
                     sda_oe_q <= ~mem_rdata[7];
                     addr_q   <= addr_q + ONE;
                  end else begin
                     state_q <= ST_AHI;
                  end
               end
               ST_AHI:  state_q <= ST_ALO;
               ST_ALO:  state_q <= ST_WR;
               default: state_q <= ST_WR;
            endcase
         end else if (scl_fall && bitcnt_q == LAST_BIT) begin
            unique case (state_q)
               ST_DEV: begin
                  if (dev_match) begin
                     ack_q    <= 1'b1;
                     sda_oe_q <= 1'b1;
                     rnw_q    <= shreg_q[0];
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
               ST_AHI: begin
                  addr_q[ADDR_W-1:BYTE_W] <= shreg_q[HI_W-1:0];
                  ack_q    <= 1'b1;
                  sda_oe_q <= 1'b1;
               end
               ST_ALO: begin
                  addr_q[BYTE_W-1:0] <= shreg_q;
                  ack_q    <= 1'b1;
                  sda_oe_q <= 1'b1;
               end
               default: begin
                  addr_q   <= addr_q + ONE;
                  ack_q    <= 1'b1;
                  sda_oe_q <= 1'b1;
               end
            endcase
         end
      end
   end

   assign sda_oe_o = sda_oe_q;

   AST_MATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEV && ack_q) |-> (shreg_q[3:1] == strap_i && shreg_q[7:4] == DEV_CODE)); // R1
   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(addr_q) == '1 && !$stable(addr_q) &&
       ($past(state_q) == ST_WR || $past(state_q) == ST_RD)) |-> addr_q == '0); // R3
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_lock_i && $past(wp_lock_i) && $stable(addr_q)) |-> $stable(mem_rdata)); // R4
   AST_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_q && !ack_q) |-> state_q == ST_RD); // R6
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_q) |-> !scl_s); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_oe_q); // R9
endmodule

// File: tb/i2cmem_target_test.sv
module i2cmem_target_test;
   localparam int MEM_AW = 11;
   localparam int QC     = 4;
   localparam logic [2:0] MY_STRAP = 3'b101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       wp = 1'b0;
   logic       sda_oe;
   logic       bus_sda;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;
   int         r8_viol = 0;
   int         hi_cnt = 0;
   logic       prev_oe = 1'b0;

   logic [7:0] model [1 << MEM_AW];
   bit         valid [1 << MEM_AW];
   logic [12:0] cur_addr = '0;

   always #10 clk = ~clk;

   assign bus_sda = sda_m & ~sda_oe;

   i2cmem_target #(.MEM_AW(MEM_AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (bus_sda),
      .sda_oe_o  (sda_oe),
      .strap_i   (MY_STRAP),
      .wp_lock_i (wp)
   );

   // R8 monitor: enable must not move during a settled clock-high phase
   always @(negedge clk) begin
      if (scl_m) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
      if (rst_n && scl_m && hi_cnt > 3 && sda_oe !== prev_oe) r8_viol = r8_viol + 1;
      prev_oe = sda_oe;
   end

   function automatic int midx(input logic [12:0] a);
      return int'(a[MEM_AW-1:0]);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tq();
      repeat (QC) @(negedge clk);
   endtask

   task automatic do_start();
      sda_m = 1'b1; tq();
      scl_m = 1'b1; tq();
      sda_m = 1'b0; tq();
      scl_m = 1'b0;
   endtask

   task automatic do_stop();
      tq();
      sda_m = 1'b0; tq();
      scl_m = 1'b1; tq();
      sda_m = 1'b1; tq();
   endtask

   task automatic clk_bit(input logic b, output logic s);
      tq(); sda_m = b;
      tq(); scl_m = 1'b1;
      tq(); s = bus_sda;
      tq(); scl_m = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
      clk_bit(1'b1, s);
      ack = (s == 1'b0);
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(~mack, s);
   endtask

   // write transfer; upper 3 bits of the high address byte are random junk (R2)
   task automatic wr_txn(input logic [12:0] a, input int n, input logic [7:0] dat [8]);
      bit ack;
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b0}, ack);
      chk(ack, "R1 write select ack", ack, 1);
      wr_byte({3'($urandom), a[12:8]}, ack);
      chk(ack, "R2 high address ack", ack, 1);
      wr_byte(a[7:0], ack);
      chk(ack, "R2 low address ack", ack, 1);
      cur_addr = a;
      for (int i = 0; i < n; i++) begin
         wr_byte(dat[i], ack);
         chk(ack, wp ? "R4 locked data ack" : "R2 data ack", ack, 1);
         if (!wp) begin
            model[midx(cur_addr)] = dat[i];
            valid[midx(cur_addr)] = 1'b1;
         end
         cur_addr = cur_addr + 13'd1;
      end
      do_stop();
   endtask

   // random read with repeated start; compares valid locations
   task automatic rd_txn(input logic [12:0] a, input int n, input string req);
      bit ack;
      logic [7:0] d;
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b0}, ack);
      wr_byte({3'b000, a[12:8]}, ack);
      wr_byte(a[7:0], ack);
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b1}, ack);
      chk(ack, "R7 read select ack", ack, 1);
      cur_addr = a;
      for (int i = 0; i < n; i++) begin
         rd_byte(i != n - 1, d);
         if (valid[midx(cur_addr)])
            chk(d == model[midx(cur_addr)], req, d, model[midx(cur_addr)]);
         cur_addr = cur_addr + 13'd1;
      end
      tq();
      chk(sda_oe == 1'b0, "R6 release after nack", sda_oe, 0);
      do_stop();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (5000 * 30) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [7:0] dat [8];
      logic [7:0] d;
      bit ack;
      void'($urandom(32'd1234));
      for (int i = 0; i < (1 << MEM_AW); i++) valid[i] = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R9 reset released", sda_oe, 0);

      // R1: wrong strap and wrong code get no ack
      do_start();
      wr_byte({4'b1010, 3'b011, 1'b0}, ack);
      chk(!ack, "R1 wrong strap nack", ack, 0);
      wr_byte(8'h00, ack);
      chk(!ack, "R1 ignored until start", ack, 0);
      do_stop();
      do_start();
      wr_byte({4'b1100, MY_STRAP, 1'b0}, ack);
      chk(!ack, "R1 wrong code nack", ack, 0);
      do_stop();

      // R2/R6: basic write then random read
      dat[0] = 8'h3C; dat[1] = 8'hA5; dat[2] = 8'h01;
      wr_txn(13'h0010, 3, dat);
      rd_txn(13'h0010, 3, "R6 read back");

      // R7: current-address read continues at 0x0013 after rd_txn
      dat[0] = 8'h77;
      wr_txn(13'h0013, 1, dat);
      rd_txn(13'h0010, 3, "R6 read prefix");
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b1}, ack);
      rd_byte(1'b0, d);
      chk(d == 8'h77, "R7 current address read", d, 8'h77);
      do_stop();

      // R3/R10: wrap across 0x1FFF, alias at 0x07FF
      dat[0] = 8'hE1; dat[1] = 8'h5A;
      wr_txn(13'h1FFF, 2, dat);
      rd_txn(13'h1FFF, 2, "R3 wrap read");
      rd_txn(13'h07FF, 1, "R10 alias read");
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b0}, ack);
      wr_byte(8'h1F, ack);
      wr_byte(8'hFF, ack);
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b1}, ack);
      rd_byte(1'b1, d);
      rd_byte(1'b0, d);
      chk(d == 8'h5A, "R3 counter wrapped to zero", d, 8'h5A);
      do_stop();

      // R4/R5: locked write acked but not stored, read works while locked
      wp = 1'b1;
      dat[0] = 8'h00; dat[1] = 8'hFF; dat[2] = 8'h99;
      wr_txn(13'h0010, 3, dat);
      rd_txn(13'h0010, 3, "R5 locked read unchanged");
      wp = 1'b0;

      // R9: byte after stop with no start is ignored
      do_start();
      wr_byte({4'b1010, MY_STRAP, 1'b0}, ack);
      do_stop();
      wr_byte({4'b1010, MY_STRAP, 1'b0}, ack);
      chk(!ack, "R9 no ack after stop", ack, 0);
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
      sda_m = 1'b1; tq(); scl_m = 1'b1; tq();

      // random mix
      for (int t = 0; t < 8; t++) begin
         logic [12:0] a;
         int n;
         a = 13'($urandom);
         n = 1 + int'($urandom % 5);
         wp = ($urandom % 3) == 0;
         for (int i = 0; i < 8; i++) dat[i] = 8'($urandom);
         wr_txn(a, n, dat);
         wp = $urandom % 2 == 1;
         rd_txn(a, n, wp ? "R5 random locked read" : "R4 random read");
         wp = 1'b0;
      end

      chk(r8_viol == 0, "R8 enable steady while clock high", r8_viol, 0);
      done = 1'b1;
      finish_run();
   end
endmodule